// File: doc/BRIEF.md
# Priority Interrupt Arbiter With Fast Path

This block sits between a bank of per-source pending flags and a CPU. It keeps one interrupt request at a time. While that request is outstanding, newer or higher-priority arrivals wait. When the CPU acknowledges, the block drops the request. For an edge-triggered source it also tells the external pending logic to clear that source's flag. It then picks the next winner, which is the enabled pending source with the highest non-zero priority.

A source does not own a priority register. A static map input selects, for each source, one entry from a smaller bank of 4-bit priority registers. A programmable fast-select register can send one chosen source to a dedicated fast-interrupt output instead of the normal one. A small byte and halfword register port holds the enable bytes, the priority bank, the fast-select register and a software-interrupt trigger. The same port flags accesses of the wrong size or to an unmapped address.

Top module: `irq_arbiter`

## Requirements
- R1: The enable bit for source n is bit (n mod 8) of the enable byte at address n div 8 (enable bytes start at address 0x00). A pending source whose enable bit is clear is never presented.
- R2: At most one request is outstanding. While it is outstanding, no other source replaces it, whatever its priority. When the block is idle, a candidate present in a cycle is presented at the next clock edge. After an acknowledge edge there is exactly one idle cycle before the next request appears.
- R3: A request word is 13 bits. Bit 12 is the valid flag, bits [11:8] hold the priority and bits [7:0] hold the source number. When the request drops, bits [11:0] keep their value and bit 12 goes to 0.
- R4: Priority registers are bytes at 0x40 + k. Only the low 4 bits of a written value are kept, and a read returns them zero-extended. Source n takes its priority from the register selected by its field in the map input (log2 of the register count bits per source, source 0 in the lowest bits).
- R5: A request goes to the fast output, and the normal output's bit 12 stays 0, when bit 15 of the fast-select register is set and its bits [7:0] equal the source number. Otherwise the request goes to the normal output. The register is a halfword at 0x80 and reads back as written.
- R6: While an acknowledge is high and a request is outstanding, the pending-clear output is one-hot on that source if it is edge-triggered (sense bit 1), and zero if it is level-triggered (sense bit 0). The request drops at that edge.
- R7: Selection picks the strictly highest priority. On a tie the lowest source number wins. A source whose priority is 0 is never presented.
- R8: Only enabled pending sources take part in selection, so a disabled source with a higher priority does not block enabled lower-priority ones.
- R9: If a level-triggered source is outstanding and its pending flag falls before acknowledge, the request is withdrawn at the next edge and no pending clear is issued.
- R10: A byte write of value 1 to address 0x84 makes the software-interrupt output high for exactly the one cycle after the write edge. Other values have no effect.
- R11: The size input is 1 for a halfword and 0 for a byte. Address 0x80 accepts only halfwords. Enable bytes, priority registers and 0x84 accept only bytes. A wrong size or an unmapped address raises the error output, a read in that case returns 0xFFFF, and a write in that case changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NSRC | Pending flags from the detection logic |
| sense_edge_i | input | NSRC | 1 = edge-triggered source, 0 = level-triggered |
| map_i | input | NSRC*log2(NPRI) | Priority register index per source |
| ack_i | input | 1 | CPU acknowledge of the outstanding request |
| irq_word_o | output | 13 | Normal request word |
| fiq_word_o | output | 13 | Fast request word |
| pend_clr_o | output | NSRC | One-hot pending clear during acknowledge |
| swi_o | output | 1 | Software-interrupt pulse |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_half_i | input | 1 | 1 = halfword access, 0 = byte |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data (combinational) |
| bus_err_o | output | 1 | Access error (combinational) |

## Verification
Arbitration is tried with several patterns, each aimed at one question:
- A single enabled source checks the word layout and the priority indirection.
- A set of sources with equal and zero priorities raised together separates strict-greater selection and lowest-index tie breaking from an implementation that takes the last or the highest index.
- A high-priority arrival behind an outstanding low-priority request shows whether the block preempts.
- A disabled high-priority source beside enabled ones shows whether enables are applied before the comparison.

Level and edge sources are acknowledged in turn to tell apart the pending-clear behaviour and the withdrawal path. The register port is probed with correct and wrong access sizes.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam logic [7:0] ADDR_EN_BASE  = 8'h00;
  localparam logic [7:0] ADDR_PRI_BASE = 8'h40;
  localparam logic [7:0] ADDR_FAST     = 8'h80;
  localparam logic [7:0] ADDR_SWI      = 8'h84;

  localparam int PRI_W  = 4;
  localparam int WORD_W = 13;

  function automatic logic [WORD_W-1:0] mk_word(input logic v,
                                                input logic [PRI_W-1:0] p,
                                                input logic [7:0] s);
    return {v, p, s};
  endfunction

endpackage

// File: rtl/irq_arb_regs.sv
module irq_arb_regs
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NPRI = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en_i,
  input  logic                  bus_we_i,
  input  logic                  bus_half_i,
  input  logic [7:0]            bus_addr_i,
  input  logic [15:0]           bus_wdata_i,
  output logic [15:0]           bus_rdata_o,
  output logic                  bus_err_o,
  output logic [NSRC-1:0]       en_o,
  output logic [NPRI*PRI_W-1:0] pri_o,
  output logic                  fast_on_o,
  output logic [7:0]            fast_src_o,
  output logic                  swi_o
);

  localparam int NEB = (NSRC + 7) / 8;

  logic [7:0]       en_q   [NEB];
  logic [7:0]       en_d   [NEB];
  logic [PRI_W-1:0] pri_q  [NPRI];
  logic [PRI_W-1:0] pri_d  [NPRI];
  logic [15:0]      fast_q, fast_d;
  logic             swi_q, swi_d;

  logic hit_en, hit_pri, hit_fast, hit_swi, acc_ok, wr_ok;

  // address decode and size check
  always_comb begin
    hit_en   = (bus_addr_i >= ADDR_EN_BASE) && (bus_addr_i < ADDR_EN_BASE + 8'(NEB));
    hit_pri  = (bus_addr_i >= ADDR_PRI_BASE) && (bus_addr_i < ADDR_PRI_BASE + 8'(NPRI));
    hit_fast = (bus_addr_i == ADDR_FAST);
    hit_swi  = (bus_addr_i == ADDR_SWI);
    acc_ok   = (hit_fast && bus_half_i) || ((hit_en || hit_pri || hit_swi) && !bus_half_i);
    bus_err_o = bus_en_i && !acc_ok;
    wr_ok    = bus_en_i && bus_we_i && acc_ok;
  end

  // read path
  always_comb begin
    bus_rdata_o = 16'hFFFF;
    if (acc_ok) begin
      bus_rdata_o = 16'h0000;
      for (int i = 0; i < NEB; i++)
        if (bus_addr_i == ADDR_EN_BASE + 8'(i)) bus_rdata_o = {8'h00, en_q[i]};
      for (int k = 0; k < NPRI; k++)
        if (bus_addr_i == ADDR_PRI_BASE + 8'(k)) bus_rdata_o = {12'h000, pri_q[k]};
      if (hit_fast) bus_rdata_o = fast_q;
    end
  end

  // next state
  always_comb begin
    for (int i = 0; i < NEB; i++) begin
      en_d[i] = en_q[i];
      if (wr_ok && bus_addr_i == ADDR_EN_BASE + 8'(i)) en_d[i] = bus_wdata_i[7:0];
    end
    for (int k = 0; k < NPRI; k++) begin
      pri_d[k] = pri_q[k];
      if (wr_ok && bus_addr_i == ADDR_PRI_BASE + 8'(k)) pri_d[k] = bus_wdata_i[PRI_W-1:0];
    end
    fast_d = (wr_ok && hit_fast) ? bus_wdata_i : fast_q;
    swi_d  = wr_ok && hit_swi && (bus_wdata_i[7:0] == 8'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NEB; i++) en_q[i] <= '0;
      for (int k = 0; k < NPRI; k++) pri_q[k] <= '0;
      fast_q <= '0;
      swi_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NEB; i++) en_q[i] <= en_d[i];
      for (int k = 0; k < NPRI; k++) pri_q[k] <= pri_d[k];
      fast_q <= fast_d;
      swi_q  <= swi_d;
    end
  end

  genvar gn, gk;
  generate
    for (gn = 0; gn < NSRC; gn++) begin : g_en
      assign en_o[gn] = en_q[gn / 8][gn % 8];
    end
    for (gk = 0; gk < NPRI; gk++) begin : g_pri
      assign pri_o[gk*PRI_W +: PRI_W] = pri_q[gk];
    end
  endgenerate

  assign fast_on_o  = fast_q[15];
  assign fast_src_o = fast_q[7:0];
  assign swi_o      = swi_q;

  // R10: a pulse only follows a byte write of 1 to the trigger address
  p_swi_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    swi_o |-> $past(bus_en_i && bus_we_i && !bus_half_i &&
                    bus_addr_i == ADDR_SWI && bus_wdata_i[7:0] == 8'd1));

  // R11: an erroring write leaves the fast-select register untouched
  p_err_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_i && bus_we_i && bus_err_o) |=> $stable(fast_q));

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       cand_i,
  input  logic [NSRC*PRI_W-1:0] pri_i,
  output logic                  win_v_o,
  output logic [SW-1:0]         win_src_o,
  output logic [PRI_W-1:0]      win_pri_o
);

  localparam int NP = 1 << SW;
  localparam int NN = 2 * NP - 1;

  logic             nv [NN];
  logic [PRI_W-1:0] np [NN];
  logic [SW-1:0]    ni [NN];

  // binary tree: leaves at NP-1+i, left child holds lower source numbers,
  // so the right child wins only on a strictly greater priority
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (i < NSRC) begin
        np[NP-1+i] = pri_i[i*PRI_W +: PRI_W];
        nv[NP-1+i] = cand_i[i] && (pri_i[i*PRI_W +: PRI_W] != '0);
      end else begin
        np[NP-1+i] = '0;
        nv[NP-1+i] = 1'b0;
      end
      ni[NP-1+i] = SW'(i);
    end
    for (int k = NP - 2; k >= 0; k--) begin
      if (nv[2*k+2] && (!nv[2*k+1] || np[2*k+2] > np[2*k+1])) begin
        nv[k] = 1'b1;
        np[k] = np[2*k+2];
        ni[k] = ni[2*k+2];
      end else begin
        nv[k] = nv[2*k+1];
        np[k] = np[2*k+1];
        ni[k] = ni[2*k+1];
      end
    end
  end

  assign win_v_o   = nv[0];
  assign win_src_o = ni[0];
  assign win_pri_o = np[0];

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NPRI = 8,
  localparam int MW = (NPRI > 1) ? $clog2(NPRI) : 1,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NSRC-1:0]      sense_edge_i,
  input  logic [NSRC*MW-1:0]   map_i,
  input  logic                 ack_i,
  output logic [WORD_W-1:0]    irq_word_o,
  output logic [WORD_W-1:0]    fiq_word_o,
  output logic [NSRC-1:0]      pend_clr_o,
  output logic                 swi_o,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic                 bus_half_i,
  input  logic [7:0]           bus_addr_i,
  input  logic [15:0]          bus_wdata_i,
  output logic [15:0]          bus_rdata_o,
  output logic                 bus_err_o
);

  logic [NSRC-1:0]       en;
  logic [NPRI*PRI_W-1:0] pri_bank;
  logic                  fast_on;
  logic [7:0]            fast_src;

  irq_arb_regs #(.NSRC(NSRC), .NPRI(NPRI)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_half_i(bus_half_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o),
    .en_o(en), .pri_o(pri_bank),
    .fast_on_o(fast_on), .fast_src_o(fast_src), .swi_o(swi_o)
  );

  // source -> priority register indirection
  logic [NSRC*PRI_W-1:0] src_pri;
  always_comb begin
    for (int n = 0; n < NSRC; n++) begin
      src_pri[n*PRI_W +: PRI_W] = '0;
      for (int k = 0; k < NPRI; k++)
        if (map_i[n*MW +: MW] == MW'(k))
          src_pri[n*PRI_W +: PRI_W] = pri_bank[k*PRI_W +: PRI_W];
    end
  end

  logic [NSRC-1:0]  cand;
  logic             win_v;
  logic [SW-1:0]    win_src;
  logic [PRI_W-1:0] win_pri;

  assign cand = pend_i & en;

  irq_arb_pick #(.NSRC(NSRC)) u_pick (
    .cand_i(cand), .pri_i(src_pri),
    .win_v_o(win_v), .win_src_o(win_src), .win_pri_o(win_pri)
  );

  // outstanding request
  logic             cur_v_q,    cur_v_d;
  logic [SW-1:0]    cur_src_q,  cur_src_d;
  logic [PRI_W-1:0] cur_pri_q,  cur_pri_d;
  logic             cur_fast_q, cur_fast_d;
  logic             cur_edge_q, cur_edge_d;

  always_comb begin
    cur_v_d    = cur_v_q;
    cur_src_d  = cur_src_q;
    cur_pri_d  = cur_pri_q;
    cur_fast_d = cur_fast_q;
    cur_edge_d = cur_edge_q;
    if (cur_v_q) begin
      if (ack_i)
        cur_v_d = 1'b0;
      else if (!cur_edge_q && !pend_i[cur_src_q])
        cur_v_d = 1'b0;
    end else if (win_v) begin
      cur_v_d    = 1'b1;
      cur_src_d  = win_src;
      cur_pri_d  = win_pri;
      cur_fast_d = fast_on && (fast_src == 8'(win_src));
      cur_edge_d = sense_edge_i[win_src];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v_q    <= 1'b0;
      cur_src_q  <= '0;
      cur_pri_q  <= '0;
      cur_fast_q <= 1'b0;
      cur_edge_q <= 1'b0;
    end else begin
      cur_v_q    <= cur_v_d;
      cur_src_q  <= cur_src_d;
      cur_pri_q  <= cur_pri_d;
      cur_fast_q <= cur_fast_d;
      cur_edge_q <= cur_edge_d;
    end
  end

  always_comb begin
    pend_clr_o = '0;
    if (ack_i && cur_v_q && cur_edge_q) pend_clr_o[cur_src_q] = 1'b1;
  end

  assign irq_word_o = mk_word(cur_v_q && !cur_fast_q, cur_pri_q, 8'(cur_src_q));
  assign fiq_word_o = mk_word(cur_v_q &&  cur_fast_q, cur_pri_q, 8'(cur_src_q));

  // R1: a newly presented source was an enabled pending candidate
  p_grant_enabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_v_q) |-> ((($past(cand) >> cur_src_q) & NSRC'(1)) != '0));

  // R2: no replacement while outstanding and neither acked nor withdrawn
  p_no_preempt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v_q && !ack_i && (cur_edge_q || pend_i[cur_src_q])) |=> (cur_v_q && $stable(cur_src_q)));

  // R6: acknowledge drops the request at that edge
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_v_q && ack_i) |=> !cur_v_q);

  // R7: a presented request never carries priority zero
  p_pri_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_v_q |-> (cur_pri_q != '0));

  // R5: the two outputs never both claim a request
  p_one_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_word_o[12] && fiq_word_o[12]));

endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 16;
  localparam int NPRI = 8;
  localparam int MW = 3;

  logic clk, rst_n;
  logic [NSRC-1:0] pend, sense_edge, pend_clr;
  logic [NSRC*MW-1:0] map;
  logic ack;
  logic [12:0] irq_word, fiq_word;
  logic swi;
  logic bus_en, bus_we, bus_half;
  logic [7:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic bus_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  irq_arbiter #(.NSRC(NSRC), .NPRI(NPRI)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .sense_edge_i(sense_edge),
    .map_i(map), .ack_i(ack), .irq_word_o(irq_word), .fiq_word_o(fiq_word),
    .pend_clr_o(pend_clr), .swi_o(swi),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_half_i(bus_half),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .bus_err_o(bus_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic h, input logic [15:0] d,
                        output logic err);
    bus_en = 1; bus_we = 1; bus_half = h; bus_addr = a; bus_wdata = d;
    #1 err = bus_err;
    tick();
    bus_en = 0; bus_we = 0; bus_half = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic h,
                        output logic [15:0] d, output logic err);
    bus_en = 1; bus_we = 0; bus_half = h; bus_addr = a;
    #1 d = bus_rdata; err = bus_err;
    bus_en = 0; bus_half = 0;
    #1;
  endtask

  task automatic wb(input logic [7:0] a, input logic [7:0] d);
    logic e;
    bus_wr(a, 1'b0, {8'h00, d}, e);
  endtask

  // acknowledge; returns the pending-clear vector seen during the ack cycle
  task automatic do_ack(output logic [NSRC-1:0] clr);
    ack = 1;
    #1 clr = pend_clr;
    tick();
    ack = 0;
    pend = pend & ~clr;
  endtask

  task automatic t_reset();
    logic [15:0] d; logic e;
    chk("R3 reset irq word", {3'b0, irq_word}, 16'h0000);
    chk("R3 reset fiq word", {3'b0, fiq_word}, 16'h0000);
    chk("R10 reset swi", {15'b0, swi}, 16'h0000);
    bus_rd(8'h00, 0, d, e);
    chk("R1 reset enable byte", d, 16'h0000);
    bus_rd(8'h80, 1, d, e);
    chk("R5 reset fast select", d, 16'h0000);
  endtask

  task automatic t_basic();
    logic [15:0] d; logic e; logic [NSRC-1:0] c;
    wb(8'h42, 8'hF5);
    bus_rd(8'h42, 0, d, e);
    chk("R4 priority low nibble kept", d, 16'h0005);
    wb(8'h00, 8'h00); wb(8'h01, 8'h04);
    pend = 16'h0400; tick();
    chk("R3 R4 word for source 10", {3'b0, irq_word}, 16'h150A);
    chk("R5 fast idle", {15'b0, fiq_word[12]}, 16'h0000);
    do_ack(c);
    chk("R6 edge clear one-hot", c, 16'h0400);
    chk("R3 drop keeps fields", {3'b0, irq_word}, 16'h050A);
    tick();
    chk("R6 stays idle after clear", {15'b0, irq_word[12]}, 16'h0000);
  endtask

  task automatic t_disabled();
    pend = 16'h0804; tick(); tick();
    chk("R1 disabled sources not presented", {15'b0, irq_word[12]}, 16'h0000);
    pend = '0;
  endtask

  task automatic t_no_preempt();
    logic [NSRC-1:0] c;
    wb(8'h41, 8'h03); wb(8'h44, 8'h09);
    wb(8'h00, 8'h12); wb(8'h01, 8'h00);
    pend = 16'h0002; tick();
    chk("R2 low source presented", {3'b0, irq_word}, 16'h1301);
    pend = 16'h0012; tick(); tick();
    chk("R2 no preemption", {3'b0, irq_word}, 16'h1301);
    do_ack(c);
    chk("R2 idle cycle after ack", {15'b0, irq_word[12]}, 16'h0000);
    tick();
    chk("R2 next winner after ack", {3'b0, irq_word}, 16'h1904);
    do_ack(c);
    tick();
  endtask

  task automatic t_ties();
    logic [NSRC-1:0] c;
    wb(8'h40, 8'h00); wb(8'h43, 8'h07); wb(8'h46, 8'h07);
    wb(8'h00, 8'h49); wb(8'h01, 8'h41);
    pend = 16'h4149; tick();
    chk("R7 tie lowest index", {3'b0, irq_word}, 16'h1703);
    do_ack(c); tick();
    chk("R7 second of tie", {3'b0, irq_word}, 16'h1706);
    do_ack(c); tick();
    chk("R7 third of tie", {3'b0, irq_word}, 16'h170E);
    do_ack(c); tick(); tick();
    chk("R7 priority zero never presented", {15'b0, irq_word[12]}, 16'h0000);
    pend = '0;
  endtask

  task automatic t_masked_high();
    logic [NSRC-1:0] c;
    wb(8'h47, 8'h0F); wb(8'h42, 8'h05);
    wb(8'h00, 8'h06); wb(8'h01, 8'h00);
    pend = 16'h0086; tick();
    chk("R8 disabled high source skipped", {3'b0, irq_word}, 16'h1502);
    do_ack(c); tick();
    chk("R8 rescan skips disabled", {3'b0, irq_word}, 16'h1301);
    do_ack(c); tick();
    pend = '0;
  endtask

  task automatic t_fast();
    logic e; logic [15:0] d; logic [NSRC-1:0] c;
    bus_wr(8'h80, 1, 16'h800A, e);
    chk("R11 halfword fast write ok", {15'b0, e}, 16'h0000);
    wb(8'h00, 8'h00); wb(8'h01, 8'h04);
    pend = 16'h0400; tick();
    chk("R5 steered to fast output", {3'b0, fiq_word}, 16'h150A);
    chk("R5 normal output quiet", {15'b0, irq_word[12]}, 16'h0000);
    do_ack(c); tick();
    bus_wr(8'h80, 1, 16'h000A, e);
    bus_rd(8'h80, 1, d, e);
    chk("R5 fast select readback", d, 16'h000A);
    pend = 16'h0400; tick();
    chk("R5 bit15 clear uses normal", {3'b0, irq_word}, 16'h150A);
    do_ack(c); tick();
  endtask

  task automatic t_level();
    logic [NSRC-1:0] c;
    wb(8'h45, 8'h04); wb(8'h00, 8'h20); wb(8'h01, 8'h00);
    pend = 16'h0020; tick();
    chk("R9 level source presented", {3'b0, irq_word}, 16'h1405);
    pend = '0;
    #1 chk("R9 no clear on withdrawal", pend_clr, 16'h0000);
    tick();
    chk("R9 withdrawn word", {3'b0, irq_word}, 16'h0405);
    pend = 16'h0020; tick();
    do_ack(c);
    chk("R6 level source not cleared", c, 16'h0000);
    tick();
    chk("R6 level re-presented", {3'b0, irq_word}, 16'h1405);
    pend = '0; tick();
  endtask

  task automatic t_swi();
    logic e;
    bus_wr(8'h84, 0, 16'h0001, e);
    chk("R10 swi pulse high", {15'b0, swi}, 16'h0001);
    tick();
    chk("R10 swi one cycle", {15'b0, swi}, 16'h0000);
    bus_wr(8'h84, 0, 16'h0002, e);
    chk("R10 other value ignored", {15'b0, swi}, 16'h0000);
  endtask

  task automatic t_errors();
    logic e; logic [15:0] d;
    bus_rd(8'h80, 0, d, e);
    chk("R11 byte read of fast err", {15'b0, e}, 16'h0001);
    chk("R11 err read data", d, 16'hFFFF);
    bus_rd(8'h00, 1, d, e);
    chk("R11 halfword enable read err", {15'b0, e}, 16'h0001);
    bus_rd(8'h30, 0, d, e);
    chk("R11 unmapped err", {15'b0, e}, 16'h0001);
    bus_wr(8'h43, 1, 16'h0009, e);
    chk("R11 halfword prio write err", {15'b0, e}, 16'h0001);
    bus_rd(8'h43, 0, d, e);
    chk("R11 err write ignored", d, 16'h0007);
    chk("R11 good read no err", {15'b0, e}, 16'h0000);
    bus_wr(8'h80, 0, 16'h0055, e);
    bus_rd(8'h80, 1, d, e);
    chk("R11 byte fast write ignored", d, 16'h000A);
  endtask

  initial begin
    rst_n = 0; pend = '0; ack = 0;
    bus_en = 0; bus_we = 0; bus_half = 0; bus_addr = '0; bus_wdata = '0;
    sense_edge = 16'hFFFF;
    sense_edge[5] = 1'b0;
    sense_edge[13] = 1'b0;
    for (int n = 0; n < NSRC; n++) map[n*MW +: MW] = MW'(n % 8);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_basic();
    t_disabled();
    t_no_preempt();
    t_ties();
    t_masked_high();
    t_fast();
    t_level();
    t_swi();
    t_errors();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule